// File: doc/BRIEF.md
# Double-Buffered 8-bit Pulse Generator Timer

This block produces a programmable pulse train on one output pin. An up counter advances on a clock enable derived from the system clock through a small prescaler. It is compared against two values: a duty value and a period value. When the counter reaches the duty value, the output leaves its idle level. When it reaches the period value, the output goes back to idle, a one-clock interrupt pulse is raised and the counter restarts from zero on its next tick. A complete cycle therefore lasts (period + 1) ticks.

A small register bus sets up the timer. It carries a run bit, the idle polarity of the output, a double-buffer enable, a clock-divider select, and the two compare values. With double buffering on, compare writes made while the timer runs are parked and only become active at the next period event, so every cycle uses one consistent pair of values. With it off, writes land at once. That brings two corner cases: a value behind the counter waits for the counter to wrap, and a value equal to the counter fires on the next clock, not on a tick boundary.

Top module: `ppg_timer`

## Requirements
- R1: After reset the output is low, the interrupt pulse is low, and all four bus addresses read back zero.
- R2: When the run bit is set with divide-by-1 selected, the counter starts from 0. It reaches value v on the v-th clock edge after the write edge. A duty match therefore changes the output duty+1 clocks after the write, and the first interrupt follows period+1 clocks after the write.
- R3: A duty match moves the output from idle to active. Polarity bit 0 makes the idle level low and the active level high; polarity bit 1 makes the idle level high and the active level low.
- R4: A period match returns the output to idle in the same clock that the interrupt pulse rises. The interrupt pulse is high for exactly one clock. With divide-by-1, consecutive interrupts are period+1 clocks apart.
- R5: Clock select values 0, 1, 2 and 3 make the counter tick every 1, 2, 4 or 8 clocks. The interrupt interval is (period+1)·2^select clocks.
- R6: When the run bit is cleared, the counter is zeroed and the output is at its idle level one clock after the write edge. A later restart counts again from 0.
- R7: With double buffering on and the timer running, a compare write changes only the buffered value. The active value takes the buffered value in the same clock as the next interrupt pulse. A read returns the last written value.
- R8: A compare write made while the timer is stopped updates the active value at once, whether double buffering is on or off.
- R9: With double buffering off, a running write of a period value below the current count takes effect at once. The next period event then comes only after the counter wraps from 0xFF through 0 up to the new value.
- R10: With double buffering off, writing a duty value equal to the current count changes the output one clock after the write edge, even if no tick occurs in that clock.
- R11: The bus map is as follows. Address 0 is control: bit 0 run, bit 1 polarity, bit 2 double-buffer enable, bits 4:3 clock select, and the upper bits read 0. Address 1 is the duty value and address 2 is the period value. Address 3 reads 0. Writes take effect on the clock edge where the write strobe is high, and read data is combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 2 | Register address |
| busWr | input | 1 | Write strobe, sampled on the rising clock edge |
| busWData | input | 8 | Write data |
| busRData | output | 8 | Read data for busAddr (combinational) |
| pwmOut | output | 1 | Pulse output |
| irqPulse | output | 1 | One-clock interrupt request at each period match |

## Verification
Every result is timed in clocks from the edge that causes it. A compare match becomes an output change one clock after the counter takes the matching value. Stopping the timer shows at the output one clock after the write edge. An equal-value duty write toggles the output on the next edge. The bench keeps a free-running edge counter and stamps each write edge and each observed output or interrupt change with it, sampling on falling edges. Each check compares a difference of stamps against the interval worked out from the requirement: duty+1, period−duty, (period+1)·2^select, or 255 for the wrap case.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  // Bus addresses; the bench and firmware rely on these.
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_DUTY   = 2'd1;
  localparam logic [1:0] ADDR_PERIOD = 2'd2;

  // Control register bit positions.
  localparam int unsigned BIT_RUN = 0;
  localparam int unsigned BIT_POL = 1;
  localparam int unsigned BIT_DBE = 2;
  localparam int unsigned BIT_SEL = 3;

  // Strobes from control to datapath.
  typedef struct packed {
    logic run;
    logic pol;
    logic dbe;
    logic tick;
    logic ldDuty;
    logic ldPeriod;
  } ppg_strb_t;
endpackage

// File: rtl/ppg_ctrl.sv
module ppg_ctrl
  import ppg_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busAddr,
  input  logic             busWr,
  input  logic [CNT_W-1:0] busWData,
  input  logic [CNT_W-1:0] dutyBuf,
  input  logic [CNT_W-1:0] periodBuf,
  output logic [CNT_W-1:0] busRData,
  output ppg_strb_t        strb
);
  localparam int unsigned PRE_W  = (1 << SEL_W) - 1;
  localparam int unsigned CTRL_W = BIT_SEL + SEL_W;

  logic             runQ, polQ, dbeQ;
  logic [SEL_W-1:0] selQ;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic             tickEn;
  logic [CTRL_W-1:0] ctrlWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ <= 1'b0;
      polQ <= 1'b0;
      dbeQ <= 1'b0;
      selQ <= '0;
    end else if (busWr && busAddr == ADDR_CTRL) begin
      runQ <= busWData[BIT_RUN];
      polQ <= busWData[BIT_POL];
      dbeQ <= busWData[BIT_DBE];
      selQ <= busWData[BIT_SEL +: SEL_W];
    end
  end

  // Prescaler: free-runs while the timer runs, held at zero otherwise.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      preCnt <= '0;
    else if (runQ)  preCnt <= preCnt + 1'b1;
    else            preCnt <= '0;
  end

  // Low 'select' bits of the prescaler must all be ones for a tick.
  always_comb begin
    for (int i = 0; i < PRE_W; i++) preMask[i] = (int'(selQ) > i);
  end
  assign tickEn = runQ & (&(preCnt | ~preMask));

  assign ctrlWord = {selQ, dbeQ, polQ, runQ};

  always_comb begin
    busRData = '0;
    case (busAddr)
      ADDR_CTRL:   busRData[CTRL_W-1:0] = ctrlWord;
      ADDR_DUTY:   busRData = dutyBuf;
      ADDR_PERIOD: busRData = periodBuf;
      default:     busRData = '0;
    endcase
  end

  assign strb.run      = runQ;
  assign strb.pol      = polQ;
  assign strb.dbe      = dbeQ;
  assign strb.tick     = tickEn;
  assign strb.ldDuty   = busWr && (busAddr == ADDR_DUTY);
  assign strb.ldPeriod = busWr && (busAddr == ADDR_PERIOD);
endmodule

// File: rtl/ppg_dp.sv
module ppg_dp
  import ppg_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ppg_strb_t        strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] dutyBuf,
  output logic [CNT_W-1:0] periodBuf,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] dutyActive,
  output logic             pwmOut,
  output logic             irqPulse
);
  logic [CNT_W-1:0] periodActive;
  logic             phaseQ, dutyHitQ, perHitQ, wrapPend, irqQ;
  logic             dutyHit, perHit, dutyEvt, perEvt, directLoad;

  assign dutyHit    = (cntVal == dutyActive);
  assign perHit     = (cntVal == periodActive);
  // A match acts once, on the clock where it becomes true.
  assign dutyEvt    = strb.run & dutyHit & ~dutyHitQ;
  assign perEvt     = strb.run & perHit  & ~perHitQ;
  assign directLoad = ~strb.run | ~strb.dbe;

  // Compare registers: the buffer always takes the write; the active copy
  // takes it at once unless the timer runs with buffering on.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyBuf      <= '0;
      periodBuf    <= '0;
      dutyActive   <= '0;
      periodActive <= '0;
    end else begin
      if (perEvt && strb.dbe) begin
        dutyActive   <= dutyBuf;
        periodActive <= periodBuf;
      end
      if (strb.ldDuty) begin
        dutyBuf <= wrData;
        if (directLoad) dutyActive <= wrData;
      end
      if (strb.ldPeriod) begin
        periodBuf <= wrData;
        if (directLoad) periodActive <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal   <= '0;
      phaseQ   <= 1'b0;
      dutyHitQ <= 1'b0;
      perHitQ  <= 1'b0;
      wrapPend <= 1'b0;
      irqQ     <= 1'b0;
    end else if (!strb.run) begin
      cntVal   <= '0;
      phaseQ   <= 1'b0;
      dutyHitQ <= 1'b0;
      perHitQ  <= 1'b0;
      wrapPend <= 1'b0;
      irqQ     <= 1'b0;
    end else begin
      dutyHitQ <= dutyHit;
      perHitQ  <= perHit;
      irqQ     <= perEvt;
      if (perEvt)       phaseQ <= 1'b0;
      else if (dutyEvt) phaseQ <= ~phaseQ;
      if (strb.tick) begin
        cntVal   <= (wrapPend || perEvt) ? '0 : cntVal + 1'b1;
        wrapPend <= 1'b0;
      end else if (perEvt) begin
        wrapPend <= 1'b1;
      end
    end
  end

  assign pwmOut   = phaseQ ^ strb.pol;
  assign irqPulse = irqQ;
endmodule

// File: rtl/ppg_timer.sv
module ppg_timer
  import ppg_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busAddr,
  input  logic             busWr,
  input  logic [CNT_W-1:0] busWData,
  output logic [CNT_W-1:0] busRData,
  output logic             pwmOut,
  output logic             irqPulse
);
  ppg_strb_t        strb;
  logic [CNT_W-1:0] dutyBuf, periodBuf, cntVal, dutyActive;

  ppg_ctrl #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busWData (busWData),
    .dutyBuf  (dutyBuf),
    .periodBuf(periodBuf),
    .busRData (busRData),
    .strb     (strb)
  );

  ppg_dp #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (busWData),
    .dutyBuf   (dutyBuf),
    .periodBuf (periodBuf),
    .cntVal    (cntVal),
    .dutyActive(dutyActive),
    .pwmOut    (pwmOut),
    .irqPulse  (irqPulse)
  );
endmodule

// File: rtl/ppg_timer_chk.sv
module ppg_timer_chk #(
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          run,
  input logic          dbe,
  input logic          pol,
  input logic          tick,
  input logic          irq,
  input logic          out,
  input logic [CW-1:0] count,
  input logic [CW-1:0] dutyAct
);
  // R4: interrupt is a single-clock pulse
  p_irq_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R4: interrupt only follows a clock in which the timer ran
  p_irq_running_r4: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(run));

  // R5: the counter moves only on a prescaler tick
  p_hold_count_r5: assert property (@(posedge clk) disable iff (!rstN)
    (run && !tick) |=> (!run || $stable(count)));

  // R6: stopping clears the counter and idles the output
  p_stop_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(run) |=> (count == '0 && out == pol));

  // R7: with buffering on, the active duty changes only with the interrupt
  p_db_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (run && dbe) |=> ($stable(dutyAct) || irq));
endmodule

bind ppg_timer ppg_timer_chk #(.CW(CNT_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .run    (strb.run),
  .dbe    (strb.dbe),
  .pol    (strb.pol),
  .tick   (strb.tick),
  .irq    (irqPulse),
  .out    (pwmOut),
  .count  (cntVal),
  .dutyAct(dutyActive)
);

// File: tb/tb_ppg_timer.sv
`timescale 1ns/1ps
module tb_ppg_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic [7:0] busWData = '0;
  logic [7:0] busRData;
  logic       pwmOut, irqPulse;

  int cyc = 0;
  int total = 0;
  int bad = 0;

  ppg_timer dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWData(busWData), .busRData(busRData), .pwmOut(pwmOut), .irqPulse(irqPulse)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Write; returns at the falling edge after the write edge, stamp = that edge.
  task automatic busWrite(input logic [1:0] a, input logic [7:0] d, output int stamp);
    @(negedge clk);
    busAddr = a; busWData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    stamp = cyc;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    int s;
    busWrite(a, d, s);
  endtask

  task automatic rdChk(input string req, input logic [1:0] a, input int exp);
    busAddr = a;
    #1;
    chk(req, int'(busRData), exp);
  endtask

  task automatic waitOut(input logic v, output int stamp);
    do @(negedge clk); while (pwmOut !== v);
    stamp = cyc;
  endtask

  task automatic waitIrq(output int stamp);
    do @(negedge clk); while (irqPulse !== 1'b1);
    stamp = cyc;
  endtask

  function automatic logic [7:0] ctl(input bit run, input bit pol, input bit dbe, input int sel);
    return 8'((sel << 3) | (int'(dbe) << 2) | (int'(pol) << 1) | int'(run));
  endfunction

  task automatic t_reset();
    chk("R1 out", int'(pwmOut), 0);
    chk("R1 irq", int'(irqPulse), 0);
    for (int a = 0; a < 4; a++) rdChk("R1/R11 readback", 2'(a), 0);
  endtask

  task automatic t_start();
    int tr, to, ti, ti2;
    wr(2'd0, ctl(0, 0, 1, 0));
    wr(2'd1, 8'd3);
    wr(2'd2, 8'd9);
    rdChk("R11 duty read", 2'd1, 3);
    rdChk("R11 period read", 2'd2, 9);
    busWrite(2'd0, ctl(1, 0, 1, 0), tr);
    waitOut(1'b1, to);
    chk("R2/R8 duty delay", to - tr, 4);
    chk("R3 active level pol0", int'(pwmOut), 1);
    waitIrq(ti);
    chk("R2/R8 first irq delay", ti - tr, 10);
    chk("R4 idle at irq", int'(pwmOut), 0);
    @(negedge clk);
    chk("R4 irq width", int'(irqPulse), 0);
    waitIrq(ti2);
    chk("R4 irq interval", ti2 - ti, 10);
  endtask

  task automatic t_dbuf();
    int t0, t1, t2, t3;
    waitOut(1'b1, t0);
    wr(2'd1, 8'd6);
    wr(2'd2, 8'd12);
    rdChk("R7 duty read buffered", 2'd1, 6);
    rdChk("R7 period read buffered", 2'd2, 12);
    waitIrq(t1);
    chk("R7 old period kept", t1 - t0, 6);
    waitOut(1'b1, t2);
    chk("R7 new duty after irq", t2 - t1, 7);
    waitIrq(t3);
    chk("R7 new period after irq", t3 - t2, 6);
  endtask

  task automatic t_stop();
    int tr, to;
    wr(2'd0, ctl(0, 0, 1, 0));
    @(negedge clk);
    chk("R6 idle after stop", int'(pwmOut), 0);
    rdChk("R11 control read", 2'd0, 4);
    busWrite(2'd0, ctl(1, 0, 1, 0), tr);
    waitOut(1'b1, to);
    chk("R6 restart from zero", to - tr, 7);
  endtask

  task automatic t_pol();
    int tr, to, ti;
    wr(2'd0, ctl(0, 0, 1, 0));
    wr(2'd0, ctl(0, 1, 1, 0));
    @(negedge clk);
    chk("R3 idle level pol1", int'(pwmOut), 1);
    busWrite(2'd0, ctl(1, 1, 1, 0), tr);
    waitOut(1'b0, to);
    chk("R3 pol1 duty delay", to - tr, 7);
    waitIrq(ti);
    chk("R3/R4 pol1 idle at irq", int'(pwmOut), 1);
  endtask

  task automatic t_div();
    int a, b;
    wr(2'd0, ctl(0, 0, 0, 0));
    wr(2'd1, 8'd1);
    wr(2'd2, 8'd5);
    for (int s = 1; s < 4; s++) begin
      wr(2'd0, ctl(1, 0, 0, s));
      waitIrq(a);
      waitIrq(b);
      chk($sformatf("R5 interval sel=%0d", s), b - a, 6 << s);
      wr(2'd0, ctl(0, 0, 0, 0));
    end
  endtask

  task automatic t_behind();
    int t0, t1;
    wr(2'd1, 8'd3);
    wr(2'd2, 8'd9);
    wr(2'd0, ctl(1, 0, 0, 0));
    waitOut(1'b1, t0);
    wr(2'd2, 8'd2);
    waitIrq(t1);
    chk("R9 wrap before match", t1 - t0, 255);
    chk("R9 idle at irq", int'(pwmOut), 0);
    wr(2'd0, ctl(0, 0, 0, 0));
  endtask

  task automatic t_equal();
    wr(2'd1, 8'd200);
    wr(2'd2, 8'd250);
    wr(2'd0, ctl(1, 0, 0, 3));
    repeat (18) @(negedge clk);
    wr(2'd1, 8'd2);
    chk("R10 not before write edge+1", int'(pwmOut), 0);
    @(negedge clk);
    chk("R10 toggle one clock after write", int'(pwmOut), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_start();
    t_dbuf();
    t_stop();
    t_pol();
    t_div();
    t_behind();
    t_equal();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule